// File: doc/BRIEF.md
# Immediate Operand Fetch Sequencer

This block is the part of an 8-bit processor core that brings in the constant bytes that follow an opcode in program memory. When `start` pulses, it latches an operation class. It then posts a read to a separate bus controller at the current program counter. It moves the program counter forward as soon as the controller accepts the request. Once the byte arrives, it writes that byte to its destination register or combines it into the accumulator.

The bus controller signals three events. `rack` means the request was accepted. `edck` is an early notice, one clock before the data is valid. `dack` marks the clock in which `busData` is valid. The sequencer leaves its wait state only on `edck`. Each execute state therefore lasts exactly one clock, and that clock coincides with `dack`. As a result, an add into the accumulator happens once per byte, however long the controller stalls. Every operand fetch, first or second, goes through one shared request state. The state that writes register B serves both the single-byte B load and the high half of the BC pair load.

Top module: `imm_fetch_seq`

## Requirements
- R1: After reset, and whenever `rstN` is low, `busy`, `done` and `busReq` are 0, `pc` equals parameter RESET_PC, and `regA`, `regB`, `regC` and `carry` are 0.
- R2: A `start` pulse while idle raises `busReq` in the next clock. While `busReq` is high, `busAddr` equals `pc`. The `opClass` encoding is: 2'b00 load B, 2'b01 load C, 2'b10 load pair BC, 2'b11 add to A.
- R3: `busReq` stays high in every clock until `rack` is sampled high. It is low in the clock after that.
- R4: `pc` increments by one on the clock edge where `busReq` and `rack` are both high, and changes at no other time.
- R5: No register changes before `edck`. The byte on `busData` in the clock after `edck` (the `dack` clock) is written exactly once. This holds regardless of how many clocks pass before `rack` or `edck`, and regardless of how long `dack` stays high afterwards.
- R6: Class 2'b00 writes the byte to `regB`. Class 2'b01 writes it to `regC`.
- R7: Class 2'b10 performs two fetches, at `pc` and then at `pc`+1. The first byte goes to `regC` and the second to `regB`.
- R8: Class 2'b11 sets `regA` to (`regA` + byte) mod 256, and sets `carry` to bit 8 of the 9-bit sum. `carry` changes only under this class.
- R9: `busy` is high from the clock after `start` through the final write clock. `done` is high only in that final write clock, and `busy` is low in the next clock.
- R10: A `start` pulse while `busy` is high is ignored. It launches no extra fetch and does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operand fetch |
| opClass | input | 2 | Operation class, encoded as in R2 |
| rack | input | 1 | Bus controller accepted the request |
| edck | input | 1 | Data will be valid in the next clock |
| dack | input | 1 | Data valid on busData this clock |
| busData | input | 8 | Byte read from program memory |
| busReq | output | 1 | Read request to the bus controller |
| busAddr | output | 16 | Read address |
| pc | output | 16 | Program counter |
| regA | output | 8 | Accumulator |
| regB | output | 8 | Register B |
| regC | output | 8 | Register C |
| carry | output | 1 | Carry from the last add |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final write of the operation this clock |

## Verification
A table of operations covers all four classes with acceptance delays from zero to three clocks and early-notice delays from zero to three clocks. A long stall before `edck` on an add separates single execution from repeated execution: repeated execution would compound the sum. Held `dack` clocks after the final byte show whether a write leaks out of the execute state. Adds that cross 256 and adds that do not tell a correct carry apart from a stuck one. Pair loads with distinct low and high bytes show the byte order and the increment of the fetch address. A `start` pulsed mid-operation with a different class, and a reset taken mid-request, complete the set.

// File: rtl/imm_fetch_pkg.sv
package imm_fetch_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_B  = 2'b00,
    OP_LOAD_C  = 2'b01,
    OP_LOAD_BC = 2'b10,
    OP_ADD_A   = 2'b11
  } opClass_e;

  typedef struct packed {
    logic incPc;
    logic wrB;
    logic wrC;
    logic addA;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LAND,
    S_WAIT_EDCK,
    S_EXEC_C,
    S_EXEC_B,
    S_EXEC_ADD
  } seqState_e;

endpackage

// File: rtl/ifs_control.sv
module ifs_control
  import imm_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opClass,
  input  logic       rack,
  input  logic       edck,
  input  logic       dack,
  output dpStrobe_t  strobe,
  output logic       busReq,
  output logic       busy,
  output logic       done
);

  seqState_e state, stateNext;
  opClass_e  curOp;
  logic      secondByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      curOp      <= OP_LOAD_B;
      secondByte <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && start) begin
        curOp      <= opClass_e'(opClass);
        secondByte <= 1'b0;
      end
      if (state == S_EXEC_C && curOp == OP_LOAD_BC)
        secondByte <= 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:      if (start) stateNext = S_LAND;
      S_LAND:      if (rack) stateNext = S_WAIT_EDCK;
      S_WAIT_EDCK: begin
        if (edck) begin
          if (curOp == OP_ADD_A)
            stateNext = S_EXEC_ADD;
          else if (curOp == OP_LOAD_B || (curOp == OP_LOAD_BC && secondByte))
            stateNext = S_EXEC_B;
          else
            stateNext = S_EXEC_C;
        end
      end
      S_EXEC_C:    stateNext = (curOp == OP_LOAD_BC) ? S_LAND : S_IDLE;
      S_EXEC_B:    stateNext = S_IDLE;
      S_EXEC_ADD:  stateNext = S_IDLE;
      default:     stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    strobe.incPc = (state == S_LAND) && rack;
    strobe.wrB   = (state == S_EXEC_B);
    strobe.wrC   = (state == S_EXEC_C);
    strobe.addA  = (state == S_EXEC_ADD);
  end

  assign busReq = (state == S_LAND);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_EXEC_B) || (state == S_EXEC_ADD) ||
                  ((state == S_EXEC_C) && (curOp != OP_LOAD_BC));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !rack) |=> busReq);

  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && rack) |=> !busReq);

  assert_exec_after_edck_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrB || strobe.wrC || strobe.addA) |-> ($past(edck) && dack));

  assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

// File: rtl/ifs_datapath.sv
module ifs_datapath
  import imm_fetch_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] busData,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] regC,
  output logic              carry
);

  localparam int SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, regA} + {1'b0, busData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc    <= RESET_PC;
      regA  <= '0;
      regB  <= '0;
      regC  <= '0;
      carry <= 1'b0;
    end else begin
      if (strobe.incPc) pc <= pc + 1'b1;
      if (strobe.wrB)   regB <= busData;
      if (strobe.wrC)   regC <= busData;
      if (strobe.addA) begin
        regA  <= sum[DATA_W-1:0];
        carry <= sum[DATA_W];
      end
    end
  end

  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrB, strobe.wrC, strobe.addA}));

  assert_carry_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.addA |=> $stable(carry));

endmodule

// File: rtl/imm_fetch_seq.sv
module imm_fetch_seq
  import imm_fetch_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opClass,
  input  logic              rack,
  input  logic              edck,
  input  logic              dack,
  input  logic [DATA_W-1:0] busData,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] regC,
  output logic              carry,
  output logic              busy,
  output logic              done
);

  dpStrobe_t strobe;

  ifs_control i_control (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opClass (opClass),
    .rack    (rack),
    .edck    (edck),
    .dack    (dack),
    .strobe  (strobe),
    .busReq  (busReq),
    .busy    (busy),
    .done    (done)
  );

  ifs_datapath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busData (busData),
    .pc      (pc),
    .regA    (regA),
    .regB    (regB),
    .regC    (regC),
    .carry   (carry)
  );

  assign busAddr = pc;

  assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && rack) |=> (pc == $past(pc) + 1'b1));

  assert_pc_still_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && rack) |=> $stable(pc));

endmodule

// File: tb/test_imm_fetch_seq.sv
module test_imm_fetch_seq;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RST_PC = 16'h0100;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] d0;
    logic [7:0] d1;
    logic [2:0] rk;
    logic [2:0] ed;
    logic [1:0] dh;
    logic       ms;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 8'h5A, 8'h00, 3'd0, 3'd0, 2'd0, 1'b0},
    '{2'b01, 8'hC3, 8'h00, 3'd2, 3'd1, 2'd0, 1'b0},
    '{2'b10, 8'h34, 8'h12, 3'd1, 3'd0, 2'd0, 1'b0},
    '{2'b11, 8'h70, 8'h00, 3'd0, 3'd3, 2'd2, 1'b0},
    '{2'b11, 8'h90, 8'h00, 3'd3, 3'd0, 2'd0, 1'b0},
    '{2'b11, 8'h01, 8'h00, 3'd0, 3'd0, 2'd1, 1'b0},
    '{2'b10, 8'hFF, 8'h00, 3'd0, 3'd2, 2'd1, 1'b1},
    '{2'b11, 8'hFF, 8'h00, 3'd1, 3'd1, 2'd0, 1'b1},
    '{2'b00, 8'h00, 8'h00, 3'd2, 3'd2, 2'd1, 1'b0},
    '{2'b11, 8'hFE, 8'h00, 3'd0, 3'd0, 2'd3, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opClass = 2'b00;
  logic        rack = 1'b0;
  logic        edck = 1'b0;
  logic        dack = 1'b0;
  logic [7:0]  busData = 8'hEE;
  logic        busReq;
  logic [15:0] busAddr;
  logic [15:0] pc;
  logic [7:0]  regA, regB, regC;
  logic        carry, busy, done;

  int checks = 0;
  int errors = 0;

  logic [15:0] expPc;
  logic [7:0]  expA, expB, expC;
  logic        expCarry;

  imm_fetch_seq i_imm_fetch_seq (
    .clk(clk), .rstN(rstN), .start(start), .opClass(opClass),
    .rack(rack), .edck(edck), .dack(dack), .busData(busData),
    .busReq(busReq), .busAddr(busAddr), .pc(pc),
    .regA(regA), .regB(regB), .regC(regC), .carry(carry),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic checkRegs(input string req);
    check(req, "regA", {24'd0, regA}, {24'd0, expA});
    check(req, "regB", {24'd0, regB}, {24'd0, expB});
    check(req, "regC", {24'd0, regC}, {24'd0, expC});
    check(req, "carry", {31'd0, carry}, {31'd0, expCarry});
    check(req, "pc", {16'd0, pc}, {16'd0, expPc});
  endtask

  task automatic runOp(input vec_t v);
    int nBytes;
    logic [7:0] b;
    logic [8:0] s;
    nBytes = (v.op == 2'b10) ? 2 : 1;
    opClass = v.op;
    start = 1'b1;
    tick();
    check("R9", "busy after start", {31'd0, busy}, 32'd1);
    for (int k = 0; k < nBytes; k++) begin
      int w;
      w = 0;
      while (!busReq && w < 8) begin
        tick();
        w++;
      end
      check("R2", "request raised", {31'd0, busReq}, 32'd1);
      if (k == 0) check("R2", "request in clock after start", w, 0);
      check("R7", "fetch address", {16'd0, busAddr}, {16'd0, expPc});
      if (v.ms && k == 0) begin
        start = 1'b1;
        opClass = ~v.op;
      end
      for (int r = 0; r < int'(v.rk); r++) begin
        tick();
        check("R3", "request held until accepted", {31'd0, busReq}, 32'd1);
        check("R4", "pc unchanged before accept", {16'd0, pc}, {16'd0, expPc});
      end
      rack = 1'b1;
      tick();
      rack = 1'b0;
      check("R3", "request dropped after accept", {31'd0, busReq}, 32'd0);
      expPc = expPc + 16'd1;
      check("R4", "pc stepped on accept", {16'd0, pc}, {16'd0, expPc});
      for (int e = 0; e < int'(v.ed); e++) begin
        busData = 8'hA5 ^ 8'(e);
        dack = (e == 0) && (k == 1) && (v.dh != 0);
        tick();
        checkRegs("R5");
      end
      dack = 1'b0;
      edck = 1'b1;
      busData = 8'h66;
      tick();
      edck = 1'b0;
      b = (k == 0) ? v.d0 : v.d1;
      dack = 1'b1;
      busData = b;
      #1;
      checkRegs("R5");
      check("R9", "done only on final write", {31'd0, done},
            {31'd0, (k == nBytes - 1)});
      case (v.op)
        2'b00: expB = b;
        2'b01: expC = b;
        2'b10: if (k == 0) expC = b; else expB = b;
        default: begin
          s = {1'b0, expA} + {1'b0, b};
          expA = s[7:0];
          expCarry = s[8];
        end
      endcase
      tick();
    end
    check("R9", "busy low after done", {31'd0, busy}, 32'd0);
    check("R9", "done is one clock", {31'd0, done}, 32'd0);
    case (v.op)
      2'b00: checkRegs("R6");
      2'b01: checkRegs("R6");
      2'b10: checkRegs("R7");
      default: checkRegs("R8");
    endcase
    for (int h = 0; h < int'(v.dh); h++) begin
      busData = 8'h3C;
      tick();
    end
    dack = 1'b0;
    busData = 8'hEE;
    tick();
    checkRegs("R5");
    check("R10", "no stray request", {31'd0, busReq}, 32'd0);
    check("R10", "idle after op", {31'd0, busy}, 32'd0);
  endtask

  task automatic resetModel();
    expPc = RST_PC;
    expA = 8'h00;
    expB = 8'h00;
    expC = 8'h00;
    expCarry = 1'b0;
  endtask

  initial begin
    resetModel();
    repeat (3) tick();
    checkRegs("R1");
    check("R1", "busy in reset", {31'd0, busy}, 32'd0);
    check("R1", "request in reset", {31'd0, busReq}, 32'd0);
    check("R1", "done in reset", {31'd0, done}, 32'd0);
    rstN = 1'b1;
    tick();
    checkRegs("R1");

    for (int i = 0; i < NVEC; i++) runOp(VECS[i]);

    opClass = 2'b11;
    start = 1'b1;
    tick();
    check("R2", "request before reset", {31'd0, busReq}, 32'd1);
    rstN = 1'b0;
    tick();
    resetModel();
    check("R1", "request cleared by reset", {31'd0, busReq}, 32'd0);
    check("R1", "busy cleared by reset", {31'd0, busy}, 32'd0);
    checkRegs("R1");
    rstN = 1'b1;
    tick();
    runOp('{2'b10, 8'h00, 8'hFF, 3'd0, 3'd0, 2'd0, 1'b0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule